// File: doc/BRIEF.md
# CAN Identifier Classifier and Forwarder

The block receives the identifier of each CAN or CAN-FD frame seen on a source bus and compares it against a small programmable set of classification entries. An entry covers either a contiguous identifier interval or two discrete identifier values, and it is tagged with a local stream index. The local index selects a row of a forwarding table. That row gives the destination port and, when the destination is reached through an Ethernet tunnel, a 32-bit tunnel stream identifier.

Entries may overlap. An identifier that satisfies several entries produces one routing request for each of them. Requests leave the block one per cycle, in ascending entry number, through a valid/ready handshake. The next identifier is taken only after the last request for the current one has been accepted. An identifier that satisfies no entry produces no request and is counted in a saturating miss counter. Software programs both tables through a single-cycle write port. Local indices only need to be unique inside this block.

Top module: `can_id_router`

## Requirements
- R1: An interval entry (control bit 1 = 0) matches when field A <= identifier <= field B, with both bounds inclusive.
- R2: A discrete entry (control bit 1 = 1) matches when the identifier equals field A or equals field B.
- R3: An entry matches only when its extended bit (control bit 2) equals `id_ext`. When `id_ext` is 0, only `id_value[10:0]` is compared and the upper bits are ignored.
- R4: Each matching entry produces exactly one request. Requests are emitted in ascending entry number, and `rt_entry` carries the entry number.
- R5: For each request, `rt_idx` is the entry's local index (control bits [13:8]), and `rt_port` and `rt_tunnel` come from forwarding row `rt_idx`. `rt_stream` carries the row's stream identifier when `rt_tunnel` is 1 and 0 otherwise.
- R6: While `rt_valid` is high and `rt_ready` is low, the request holds. `id_ready` stays low until the last request of the current identifier has been accepted, and is high in the cycle after that.
- R7: An accepted identifier with no match produces no request and raises `miss_cnt` by one in the next cycle. `miss_cnt` saturates at all ones and changes only when an identifier is accepted.
- R8: An entry whose enable bit (control bit 0) is 0 never matches.
- R9: After reset, `id_ready` is 1, `rt_valid` is 0, `miss_cnt` is 0 and every entry is disabled.
- R10: When `cfg_we` is 1 at a clock edge, the write takes effect. With `cfg_fwd` = 0, `cfg_fld` 0/1/2 writes the control word, field A or field B of entry `cfg_idx`. With `cfg_fwd` = 1, `cfg_fld` 0 writes port (bits [PORT_W-1:0]) and tunnel flag (bit 8), and `cfg_fld` 1 writes the stream identifier of row `cfg_idx`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_fwd | input | 1 | 0 selects the classification table, 1 selects the forwarding table |
| cfg_idx | input | IDX_W | Entry number or forwarding row |
| cfg_fld | input | 2 | Field select |
| cfg_wdata | input | 32 | Write data |
| id_valid | input | 1 | Identifier offered |
| id_ready | output | 1 | Identifier accepted when high together with id_valid |
| id_value | input | ID_W | Frame identifier |
| id_ext | input | 1 | 1 for an extended 29-bit identifier, 0 for standard 11-bit |
| rt_valid | output | 1 | Routing request present |
| rt_ready | input | 1 | Downstream takes the request |
| rt_entry | output | ENT_W | Number of the matching entry |
| rt_idx | output | IDX_W | Local stream index |
| rt_port | output | PORT_W | Destination port |
| rt_tunnel | output | 1 | Destination is reached through a tunnel stream |
| rt_stream | output | 32 | Tunnel stream identifier, 0 when not tunnelled |
| miss_cnt | output | MISS_W | Saturating count of unmatched identifiers |

## Verification
On every cycle, assertions check that a stalled request holds its entry, that successive requests for one identifier rise in entry number, and that the input reopens right after the final request. They also check that the miss counter moves only when an identifier is accepted and stays at its ceiling once it gets there. The bench's scenarios are what show that the correct set of entries matches. Those scenarios cover:
- interval bounds and discrete hits;
- agreement of the standard and extended flags;
- disabled entries;
- forwarding rows that several entries share;
- rewriting an entry while the block is running.

A reference model in the bench computes the expected match list for each identifier and compares it with the requests the block emits.

// File: rtl/can_id_router.sv
module can_id_router #(
  parameter int N_ENT  = 8,
  parameter int ID_W   = 29,
  parameter int IDX_W  = 6,
  parameter int PORT_W = 4,
  parameter int MISS_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_fwd,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [1:0]        cfg_fld,
  input  logic [31:0]       cfg_wdata,
  input  logic              id_valid,
  output logic              id_ready,
  input  logic [ID_W-1:0]   id_value,
  input  logic              id_ext,
  output logic              rt_valid,
  input  logic              rt_ready,
  output logic [$clog2(N_ENT)-1:0] rt_entry,
  output logic [IDX_W-1:0]  rt_idx,
  output logic [PORT_W-1:0] rt_port,
  output logic              rt_tunnel,
  output logic [31:0]       rt_stream,
  output logic [MISS_W-1:0] miss_cnt
);
  localparam int ENT_W = $clog2(N_ENT);
  localparam int ROWS  = 1 << IDX_W;

  logic              cl_en  [N_ENT];
  logic              cl_set [N_ENT];
  logic              cl_ext [N_ENT];
  logic [IDX_W-1:0]  cl_idx [N_ENT];
  logic [ID_W-1:0]   cl_a   [N_ENT];
  logic [ID_W-1:0]   cl_b   [N_ENT];
  logic [PORT_W-1:0] fw_port[ROWS];
  logic              fw_tun [ROWS];
  logic [31:0]       fw_sid [ROWS];

  logic [N_ENT-1:0] hit, pend;
  logic [ENT_W-1:0] cur;
  logic [ID_W-1:0]  idm;
  logic             take;

  assign idm      = id_ext ? id_value : {{(ID_W-11){1'b0}}, id_value[10:0]};
  assign id_ready = ~|pend;
  assign take     = id_valid & id_ready;
  assign rt_valid = |pend;

  always_comb begin
    for (int e = 0; e < N_ENT; e++)
      hit[e] = cl_en[e] && (cl_ext[e] == id_ext) &&
               (cl_set[e] ? (idm == cl_a[e] || idm == cl_b[e])
                          : (idm >= cl_a[e] && idm <= cl_b[e]));
  end

  always_comb begin
    cur = '0;
    for (int e = N_ENT - 1; e >= 0; e--)
      if (pend[e]) cur = ENT_W'(e);
  end

  assign rt_entry  = cur;
  assign rt_idx    = cl_idx[cur];
  assign rt_port   = fw_port[rt_idx];
  assign rt_tunnel = fw_tun[rt_idx];
  assign rt_stream = rt_tunnel ? fw_sid[rt_idx] : 32'h0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend     <= '0;
      miss_cnt <= '0;
    end else if (take) begin
      pend <= hit;
      if (hit == '0 && miss_cnt != {MISS_W{1'b1}}) miss_cnt <= miss_cnt + 1'b1;
    end else if (rt_valid && rt_ready) begin
      pend[cur] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int e = 0; e < N_ENT; e++) begin
        cl_en[e] <= 1'b0; cl_set[e] <= 1'b0; cl_ext[e] <= 1'b0;
        cl_idx[e] <= '0;  cl_a[e] <= '0;     cl_b[e] <= '0;
      end
      for (int r = 0; r < ROWS; r++) begin
        fw_port[r] <= '0; fw_tun[r] <= 1'b0; fw_sid[r] <= '0;
      end
    end else if (cfg_we) begin
      if (cfg_fwd) begin
        if (cfg_fld == 2'd0) begin
          fw_port[cfg_idx] <= cfg_wdata[PORT_W-1:0];
          fw_tun[cfg_idx]  <= cfg_wdata[8];
        end else if (cfg_fld == 2'd1) begin
          fw_sid[cfg_idx] <= cfg_wdata;
        end
      end else begin
        for (int e = 0; e < N_ENT; e++)
          if (cfg_idx == IDX_W'(e)) begin
            case (cfg_fld)
              2'd0: begin
                cl_en[e]  <= cfg_wdata[0];
                cl_set[e] <= cfg_wdata[1];
                cl_ext[e] <= cfg_wdata[2];
                cl_idx[e] <= cfg_wdata[8 +: IDX_W];
              end
              2'd1: cl_a[e] <= cfg_wdata[ID_W-1:0];
              2'd2: cl_b[e] <= cfg_wdata[ID_W-1:0];
              default: ;
            endcase
          end
      end
    end
  end

  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    rt_valid && !rt_ready |=> rt_valid && $stable(rt_entry)); // R6
  AST_ASCEND_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    rt_valid && rt_ready && ($countones(pend) > 1) |=> rt_valid && (rt_entry > $past(rt_entry))); // R4
  AST_REOPEN: assert property (@(posedge clk) disable iff (!rst_n)
    rt_valid && rt_ready && ($countones(pend) == 1) |=> id_ready && !rt_valid); // R6
  AST_MISS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !(id_valid && id_ready) |=> $stable(miss_cnt)); // R7
  AST_MISS_CEIL: assert property (@(posedge clk) disable iff (!rst_n)
    miss_cnt == {MISS_W{1'b1}} |=> miss_cnt == {MISS_W{1'b1}}); // R7
endmodule

// File: tb/sim_can_id_router.sv
module sim_can_id_router;
  localparam int N_ENT = 8, ID_W = 29, IDX_W = 6, PORT_W = 4, MISS_W = 8;

  logic clk = 0, rst_n = 0;
  logic cfg_we = 0, cfg_fwd = 0;
  logic [IDX_W-1:0] cfg_idx = '0;
  logic [1:0] cfg_fld = '0;
  logic [31:0] cfg_wdata = '0;
  logic id_valid = 0, id_ext = 0, rt_ready = 0;
  logic [ID_W-1:0] id_value = '0;
  logic id_ready, rt_valid, rt_tunnel;
  logic [2:0] rt_entry;
  logic [IDX_W-1:0] rt_idx;
  logic [PORT_W-1:0] rt_port;
  logic [31:0] rt_stream;
  logic [MISS_W-1:0] miss_cnt;

  always #10 clk = ~clk;

  can_id_router u0 (.clk, .rst_n, .cfg_we, .cfg_fwd, .cfg_idx, .cfg_fld, .cfg_wdata,
    .id_valid, .id_ready, .id_value, .id_ext, .rt_valid, .rt_ready, .rt_entry,
    .rt_idx, .rt_port, .rt_tunnel, .rt_stream, .miss_cnt);

  bit m_en[N_ENT], m_set[N_ENT], m_ext[N_ENT];
  int m_idx[N_ENT];
  logic [ID_W-1:0] m_a[N_ENT], m_b[N_ENT];
  int f_port[64];
  bit f_tun[64];
  logic [31:0] f_sid[64];
  int nchk = 0, nfail = 0, exp_miss = 0;

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] ctrl(bit en, bit set, bit ext, int idx);
    return {18'b0, 6'(idx), 5'b0, ext, set, en};
  endfunction

  task automatic cfg_wr(bit fwd, int idx, int fld, logic [31:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_fwd = fwd; cfg_idx = IDX_W'(idx); cfg_fld = 2'(fld); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
    if (fwd) begin
      if (fld == 0) begin f_port[idx] = int'(d[3:0]); f_tun[idx] = d[8]; end
      else f_sid[idx] = d;
    end else if (fld == 0) begin
      m_en[idx] = d[0]; m_set[idx] = d[1]; m_ext[idx] = d[2]; m_idx[idx] = int'(d[13:8]);
    end else if (fld == 1) m_a[idx] = d[ID_W-1:0];
    else m_b[idx] = d[ID_W-1:0];
  endtask

  task automatic entry(int e, bit set, bit ext, int idx, int a, int b);
    cfg_wr(0, e, 1, 32'(a));
    cfg_wr(0, e, 2, 32'(b));
    cfg_wr(0, e, 0, ctrl(1, set, ext, idx));
  endtask

  task automatic run_id(logic [ID_W-1:0] id, bit ext, int stall, string tag);
    int exp_e[$];
    logic [ID_W-1:0] idm;
    idm = ext ? id : {18'b0, id[10:0]};
    for (int e = 0; e < N_ENT; e++)
      if (m_en[e] && m_ext[e] == ext &&
          (m_set[e] ? (idm == m_a[e] || idm == m_b[e]) : (idm >= m_a[e] && idm <= m_b[e])))
        exp_e.push_back(e);
    @(negedge clk);
    chk(id_ready == 1, "R6", "ready before offer", id_ready, 1);
    id_valid = 1; id_value = id; id_ext = ext;
    @(negedge clk);
    id_valid = 0;
    if (exp_e.size() == 0) begin
      if (exp_miss < 255) exp_miss++;
      chk(rt_valid == 0, tag, "no request on miss", rt_valid, 0);
      chk(int'(miss_cnt) == exp_miss, "R7", "miss count", miss_cnt, exp_miss);
    end else begin
      foreach (exp_e[k]) begin
        int e, ix;
        e = exp_e[k];
        ix = m_idx[e];
        while (int'($urandom_range(99)) < stall) begin
          rt_ready = 0;
          chk(rt_valid && int'(rt_entry) == e && !id_ready, "R6", "stalled request", rt_entry, e);
          @(negedge clk);
        end
        rt_ready = 1;
        chk(rt_valid == 1, tag, "request present", rt_valid, 1);
        chk(int'(rt_entry) == e, tag, "entry order R4", rt_entry, e);
        chk(int'(rt_idx) == ix, "R5", "local index", rt_idx, ix);
        chk(int'(rt_port) == f_port[ix], "R5", "port", rt_port, f_port[ix]);
        chk(rt_tunnel == f_tun[ix], "R5", "tunnel flag", rt_tunnel, f_tun[ix]);
        chk(rt_stream == (f_tun[ix] ? f_sid[ix] : 32'h0), "R5", "stream", rt_stream,
            f_tun[ix] ? f_sid[ix] : 0);
        @(negedge clk);
        rt_ready = 0;
      end
      chk(rt_valid == 0 && id_ready == 1, "R6", "drained", {rt_valid, id_ready}, 1);
      chk(int'(miss_cnt) == exp_miss, "R7", "miss unchanged on hit", miss_cnt, exp_miss);
    end
  endtask

  initial begin
    #(20 * 150000);
    nchk++; nfail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    int pool[13];
    pool = '{'h0FF, 'h100, 'h104, 'h110, 'h111, 'h153, 'h1FF, 'h200, 'h2FF, 'h300, 'h7FF, 'h1017, 'h5};
    void'($urandom(32'h5EED));
    for (int r = 0; r < 64; r++) begin f_port[r] = 0; f_tun[r] = 0; f_sid[r] = 0; end
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(id_ready == 1, "R9", "reset id_ready", id_ready, 1);
    chk(rt_valid == 0, "R9", "reset rt_valid", rt_valid, 0);
    chk(miss_cnt == 0, "R9", "reset miss", miss_cnt, 0);
    run_id('h104, 0, 0, "R9");

    entry(0, 0, 0, 1, 'h100, 'h110);
    entry(1, 0, 0, 2, 'h200, 'h2FF);
    entry(2, 1, 1, 3, 'h153, 'h1017);
    entry(3, 0, 0, 4, 'h100, 'h1FF);
    entry(4, 1, 0, 3, 'h153, 'h7FF);
    entry(5, 0, 1, 5, 'h100, 'h110);
    cfg_wr(0, 6, 1, 0); cfg_wr(0, 6, 2, 'h7FF); cfg_wr(0, 6, 0, ctrl(0, 0, 0, 6));
    entry(7, 0, 0, 7, 'h104, 'h104);
    cfg_wr(1, 1, 0, 32'h100); cfg_wr(1, 1, 1, 32'h3302_2104);
    cfg_wr(1, 2, 0, 32'h100); cfg_wr(1, 2, 1, 32'hAB60_0177);
    cfg_wr(1, 3, 0, 32'h101); cfg_wr(1, 3, 1, 32'h87A1_BF87);
    cfg_wr(1, 4, 0, 32'h002); cfg_wr(1, 4, 1, 32'h0000_DEAD);
    cfg_wr(1, 5, 0, 32'h103); cfg_wr(1, 5, 1, 32'h0000_1234);
    cfg_wr(1, 7, 0, 32'h005);

    run_id('h104, 0, 30, "R4");
    run_id('h100, 0, 0, "R1");
    run_id('h110, 0, 0, "R1");
    run_id('h111, 0, 0, "R1");
    run_id('h0FF, 0, 0, "R1");
    run_id('h153, 0, 40, "R2");
    run_id('h7FF, 0, 0, "R2");
    run_id('h1017, 1, 0, "R2");
    run_id('h153, 1, 0, "R3");
    run_id('h104, 1, 0, "R3");
    run_id('h1017, 0, 0, "R3");
    run_id(29'h1_5104, 0, 0, "R3");
    run_id('h300, 0, 0, "R8");

    for (int n = 0; n < 300; n++) begin
      logic [ID_W-1:0] v;
      v = (n % 7 == 6) ? ID_W'($urandom) : ID_W'(pool[$urandom_range(12)]);
      run_id(v, 1'($urandom_range(1)), 35, "R4");
    end

    entry(7, 1, 1, 7, 'h5, 'h1017);
    cfg_wr(1, 7, 0, 32'h109); cfg_wr(1, 7, 1, 32'hCAFE_0007);
    run_id('h1017, 1, 0, "R10");
    run_id('h5, 1, 0, "R10");
    cfg_wr(0, 0, 0, ctrl(0, 0, 0, 1));
    run_id('h104, 0, 0, "R8");

    for (int n = 0; n < 260; n++) run_id('h300, 0, 0, "R7");
    chk(miss_cnt == 8'hFF, "R7", "saturated", miss_cnt, 'hFF);

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule